// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block sits between a flash array and its data pins. While an embedded program or erase runs, or an erase is suspended, it replaces the array word on reads with a status byte. Software polls that byte to follow the operation. One bit gives a completion poll. Two bits toggle on successive reads: one means "an operation is active" and the other means "this address lies in a sector selected for erase". A further bit shows whether the window for adding more sectors to an erase has closed. When the controller is idle, reads return the array data unchanged.

The command decoder supplies the operation phase, the byte being programmed and the mask of sectors selected for erase. A read access is one cycle of `rd_stb`. The byte returned by that access is registered and appears on `dout` in the following cycle. It then holds until the next access. The sector of a read is the top `SECT_BITS` bits of `rd_addr`.

Phase codes: 0 idle, 1 program busy, 2 erase window open, 3 erase busy, 4 erase suspended. Codes 5 to 7 are treated as idle.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `dout` is 8'h00 and both toggle bits start at 0. The first status read therefore shows bit 6 = 0 and, in a selected sector, bit 2 = 0.
- R2: In phase 0 (idle), a read returns `array_data` on `dout` in the cycle after `rd_stb`. The toggle bits do not advance.
- R3: Each read that returns status inverts bit 6 relative to the previous status read. This applies in phases 1 to 4.
- R4: In phases 2, 3 and 4, bit 2 inverts on each status read whose address lies in a selected sector (`erase_sel[sector]` = 1). On any other status read, bit 2 reads 1 and its toggle state is kept.
- R5: Bit 3 reads 1 in phases 3 and 4 and reads 0 in phases 1 and 2.
- R6: Bit 7 reads the inverse of `prog_data[7]` in phase 1 and reads 0 in phases 2, 3 and 4.
- R7: In phase 4, a read outside the selected sectors returns `array_data` and advances neither toggle bit.
- R8: In a status byte, bits 5, 4, 1 and 0 read 0.
- R9: Phase codes 5, 6 and 7 behave as idle: the read returns array data and the toggles do not advance.
- R10: `dout` changes only in the cycle after a cycle with `rd_stb` high. Without a read, it holds regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 3 | Controller phase code |
| prog_data | input | 8 | Byte being programmed |
| erase_sel | input | 2**SECT_BITS | Sectors selected for erase, one bit per sector |
| rd_addr | input | ADDR_W | Read address; top SECT_BITS bits give the sector |
| rd_stb | input | 1 | One cycle per read access |
| array_data | input | 8 | Word read from the array |
| dout | output | 8 | Byte returned to the data pins |

## Verification
Reads are issued in every phase code. In program, two values of the programmed byte's top bit separate the inverted poll from a fixed level. In the erase phases, addresses are placed alternately inside and outside the selected sector. This shows that bit 2 toggles only in selected sectors while bit 6 keeps toggling. During suspend, an unselected read placed between two selected reads proves that array data passes through and that neither toggle advances. Idle reads, unused phase codes and stretches with no strobe show that the toggles and `dout` stay put.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int ADDR_W    = 12,
  parameter int SECT_BITS = 4,
  localparam int NSECT    = 1 << SECT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        phase,
  input  logic [7:0]        prog_data,
  input  logic [NSECT-1:0]  erase_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_stb,
  input  logic [7:0]        array_data,
  output logic [7:0]        dout
);

  logic tog6, tog2;

  wire [SECT_BITS-1:0] sect = rd_addr[ADDR_W-1 -: SECT_BITS];
  wire in_sel  = erase_sel[sect];
  wire p_prog  = (phase == 3'd1);
  wire p_win   = (phase == 3'd2);
  wire p_bsy   = (phase == 3'd3);
  wire p_sus   = (phase == 3'd4);
  wire erasing = p_win | p_bsy | p_sus;
  wire show    = p_prog | p_win | p_bsy | (p_sus & in_sel);
  wire flip2   = erasing & in_sel;

  wire [7:0] status = {p_prog & ~prog_data[7], tog6, 2'b00,
                       p_bsy | p_sus, flip2 ? tog2 : 1'b1, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= 8'h00;
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (rd_stb) begin
      dout <= show ? status : array_data;
      if (show) tog6 <= ~tog6;
      if (show && flip2) tog2 <= ~tog2;
    end
  end

endmodule

module flash_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic [7:0] prog_data,
  input logic       rd_stb,
  input logic [7:0] array_data,
  input logic [7:0] dout
);

  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(dout));

  a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && phase == 3'd0) |=> dout == $past(array_data));

  a_r6_program_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && phase == 3'd1) |=> dout[7] == !$past(prog_data[7]));

  a_r5_window_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (phase == 3'd1 || phase == 3'd2)) |=> !dout[3]);

  a_r5_busy_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && phase == 3'd3) |=> dout[3]);

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && phase >= 3'd1 && phase <= 3'd3) |=> (dout & 8'h33) == 8'h00);

endmodule

bind flash_status_gen flash_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .prog_data(prog_data),
  .rd_stb(rd_stb), .array_data(array_data), .dout(dout)
);

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  phase = 3'd0;
  logic [7:0]  prog_data = 8'h00;
  logic [15:0] erase_sel = 16'h0000;
  logic [11:0] rd_addr = 12'h000;
  logic        rd_stb = 1'b0;
  logic [7:0]  array_data = 8'h00;
  logic [7:0]  dout;

  int tests = 0, fails = 0;
  logic m6 = 1'b0, m2 = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_gen u0 (.clk(clk), .rst_n(rst_n), .phase(phase), .prog_data(prog_data),
    .erase_sel(erase_sel), .rd_addr(rd_addr), .rd_stb(rd_stb),
    .array_data(array_data), .dout(dout));

  task automatic chk(input string tag, input logic [7:0] exp);
    tests++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected=%h", tag, dout, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); rd_addr = a; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  // status read; b2sel: address in selected sector during erase phases
  task automatic st_rd(input string tag, input logic [11:0] a, input logic b7,
                       input logic b3, input logic b2sel);
    logic b2;
    rd(a);
    b2 = b2sel ? m2 : 1'b1;
    chk(tag, {b7, m6, 2'b00, b3, b2, 2'b00});
    m6 = ~m6;
    if (b2sel) m2 = ~m2;
  endtask

  task automatic t_reset;
    chk("R1 reset dout", 8'h00);
  endtask

  task automatic t_idle;
    phase = 3'd0; array_data = 8'hA5; rd(12'h123); chk("R2 idle read", 8'hA5);
    array_data = 8'h3C; rd(12'h456); chk("R2 idle read 2", 8'h3C);
    phase = 3'd6; array_data = 8'h99; rd(12'h100); chk("R9 phase 6 idle", 8'h99);
    phase = 3'd7; array_data = 8'h17; rd(12'h100); chk("R9 phase 7 idle", 8'h17);
  endtask

  task automatic t_prog;
    phase = 3'd1; erase_sel = 16'hFFFF;
    prog_data = 8'h80; st_rd("R1 R3 R6 R8 program read 1", 12'h200, 1'b0, 1'b0, 1'b0);
    st_rd("R3 R4 program read 2", 12'h200, 1'b0, 1'b0, 1'b0);
    prog_data = 8'h00; st_rd("R6 R5 program poll inverted", 12'h200, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    logic [7:0] keep;
    keep = dout;
    phase = 3'd0; array_data = 8'hEE; prog_data = 8'hFF;
    repeat (6) @(negedge clk);
    chk("R10 hold without read", keep);
  endtask

  task automatic t_window;
    phase = 3'd2; erase_sel = 16'h0002;
    st_rd("R1 R4 window selected read 1", 12'h1A0, 1'b0, 1'b0, 1'b1);
    st_rd("R4 window selected read 2", 12'h1A4, 1'b0, 1'b0, 1'b1);
    st_rd("R4 R5 window unselected", 12'h3A0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busy;
    phase = 3'd3;
    st_rd("R5 R6 busy selected", 12'h150, 1'b0, 1'b1, 1'b1);
    st_rd("R4 busy selected again", 12'h160, 1'b0, 1'b1, 1'b1);
    st_rd("R4 busy unselected", 12'hF00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_suspend;
    phase = 3'd4;
    st_rd("R5 suspend selected", 12'h111, 1'b0, 1'b1, 1'b1);
    array_data = 8'h5A; rd(12'h811); chk("R7 suspend unselected data", 8'h5A);
    st_rd("R7 R3 suspend toggles kept", 12'h122, 1'b0, 1'b1, 1'b1);
    phase = 3'd0; array_data = 8'hC3; rd(12'h111); chk("R2 done returns data", 8'hC3);
    phase = 3'd3; st_rd("R2 idle did not advance toggles", 12'h111, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_idle; t_prog; t_hold; t_window; t_busy; t_suspend;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule